// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable ratio of N·P + A. It does so with a dual-modulus prescaler that divides by either P or P+1, plus two down counters. The main counter counts prescaler groups and sets the length of each output period. The swallow counter keeps the prescaler at P+1 for the first A groups of every period and then lets it fall back to P for the rest. A phase detector sits downstream of this block and takes one single-cycle pulse on `div_out` per period.

The programmed pair (N, A) is taken from the input pins only at a period boundary, so a change part-way through a period cannot produce a malformed period. A pair that cannot be divided (N of zero, A above N, or A above P-1) is not used. In that case the block stops, raises `cfg_err` and waits. It resumes as soon as a legal pair appears on the inputs. The prescaler modulus P and the width of N are parameters. The width of A is derived from P.

Top module: `psw_divider`

## Requirements
- R1: With a legal pair (N, A) in force, consecutive rising edges of `div_out` are exactly N·P + A input clocks apart, and each pulse lasts exactly one clock.
- R2: Within one output period, `mod_ctl` is low (modulus P+1) for exactly A·(P+1) clocks and high (modulus P) for the remaining clocks. The low clocks form the start of the period, which begins with the clock in which `div_out` is high.
- R3: The prescaler group lasts P+1 clocks while `mod_ctl` is low and P clocks while it is high. `pre_out` is high in the first clock of every group, so it shows exactly N rising edges per output period. `mod_ctl` changes only at group starts.
- R4: A pair is illegal when N = 0, A > N, or A > P-1. Once an illegal pair has been taken at a boundary, `cfg_err` reads 1, `div_out` stays low and `mod_ctl` stays high until a legal pair is taken.
- R5: `n_val` and `a_val` are sampled only on the clock edge that ends a period (the edge that raises `div_out`), or on every edge while stopped. Changes between those edges have no effect on the running period.
- R6: While stopped, a legal pair is taken on the next edge. At that edge `cfg_err` clears and counting starts, and the first `div_out` pulse arrives N·P + A clocks later.
- R7: During reset, `div_out`, `pre_out` and `cfg_err` are 0 and `mod_ctl` is 1.
- R8: A = 0 keeps `mod_ctl` high for the whole period. A = P-1 with N = P-1 gives the ratio (P-1)·P + P-1, with `mod_ctl` low for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | High-speed input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| n_val | input | N_W | Programmed group count N |
| a_val | input | A_W = $clog2(P) | Programmed swallow count A |
| div_out | output | 1 | One-clock pulse per output period, to the phase detector |
| mod_ctl | output | 1 | Modulus control: 1 selects ÷P, 0 selects ÷(P+1) |
| pre_out | output | 1 | Prescaler output, high in the first clock of each group |
| cfg_err | output | 1 | Set while an illegal pair is in force and the divider is stopped |

## Verification
The bench builds the divider with P = 4 and N_W = 5. This makes the legal space small enough to visit every (N, A) pair with N from 1 to 31 and A from 0 to 3, in a chain in which each period checks the pair loaded one step earlier. Because P is a power of two in this build, the only reachable illegal pairs are A > N and N = 0. Both are driven, and so is the recovery from them. The extremes A = 0, A = P-1 and N = A are all part of the sweep, and a change of the inputs in the middle of a period is shown to be ignored.

// File: rtl/psw_pkg.sv
package psw_pkg;

   typedef enum logic {
      DIV_STOPPED = 1'b0,
      DIV_RUNNING = 1'b1
   } div_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/psw_cfg_check.sv
module psw_cfg_check #(
   parameter int unsigned P   = 8,
   parameter int unsigned N_W = 10,
   parameter int unsigned A_W = 3
) (
   input  logic [N_W-1:0] n_in,
   input  logic [A_W-1:0] a_in,
   output logic           legal
);
   import psw_pkg::*;

   localparam bit P_POW2 = is_pow2(P);
   localparam logic [A_W-1:0] A_MAX = A_W'(P - 1);

   logic n_ok;
   logic a_le_n;
   logic a_in_range;

   assign n_ok   = (n_in != '0);
   assign a_le_n = ({{(N_W-A_W){1'b0}}, a_in} <= n_in);

   generate
      if (P_POW2) begin : g_range_free
         // the field width already limits A to P-1
         assign a_in_range = 1'b1;
      end else begin : g_range_cmp
         assign a_in_range = (a_in <= A_MAX);
      end
   endgenerate

   assign legal = n_ok && a_le_n && a_in_range;

endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
   parameter int unsigned P = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic mc,
   output logic tick,
   output logic pre_out
);
   localparam int unsigned PC_W = $clog2(P + 1);
   localparam logic [PC_W-1:0] LAST_HI = PC_W'(P - 1);
   localparam logic [PC_W-1:0] LAST_LO = PC_W'(P);

   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] pc_last;

   assign pc_last = mc ? LAST_HI : LAST_LO;
   assign tick    = run && (pc == pc_last);
   assign pre_out = run && (pc == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= '0;
      end else if (!run || tick) begin
         pc <= '0;
      end else begin
         pc <= pc + 1'b1;
      end
   end

   // R3: group position never passes the longer modulus
   p_group_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pc <= LAST_LO);

   // R3: modulus control only moves at group starts
   p_mc_group_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && pc != '0) |-> $stable(mc));

endmodule

// File: rtl/psw_swallow.sv
module psw_swallow #(
   parameter int unsigned N_W = 10,
   parameter int unsigned A_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           clr,
   input  logic           tick,
   input  logic [N_W-1:0] n_ld,
   input  logic [A_W-1:0] a_ld,
   output logic           mc,
   output logic           last
);
   localparam logic [N_W-1:0] N_ONE = N_W'(1);

   logic [N_W-1:0] n_cnt;
   logic [A_W-1:0] a_cnt;

   assign mc   = (a_cnt == '0);
   assign last = tick && (n_cnt == N_ONE);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         n_cnt <= '0;
         a_cnt <= '0;
      end else if (load) begin
         n_cnt <= n_ld;
         a_cnt <= a_ld;
      end else if (tick) begin
         n_cnt <= n_cnt - 1'b1;
         if (a_cnt != '0) begin
            a_cnt <= a_cnt - 1'b1;
         end
      end
   end

   // R4: swallow count never exceeds remaining groups
   p_a_within_n_r4: assert property (@(posedge clk) disable iff (!rst_n)
      {{(N_W-A_W){1'b0}}, a_cnt} <= n_cnt);

   // R1: a tick never arrives on an empty group counter
   p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (n_cnt != '0));

endmodule

// File: rtl/psw_divider.sv
module psw_divider #(
   parameter int unsigned P   = 8,
   parameter int unsigned N_W = 10,
   parameter int unsigned A_W = $clog2(P)
) (
   input  logic           clk_in,
   input  logic           rst_n,
   input  logic [N_W-1:0] n_val,
   input  logic [A_W-1:0] a_val,
   output logic           div_out,
   output logic           mod_ctl,
   output logic           pre_out,
   output logic           cfg_err
);
   import psw_pkg::*;

   generate
      if (P < 2) begin : g_bad_p
         $error("psw_divider: P must be at least 2");
      end
      if (A_W != $clog2(P)) begin : g_bad_aw
         $error("psw_divider: A_W must equal clog2(P)");
      end
      if (N_W <= A_W) begin : g_bad_nw
         $error("psw_divider: N_W must exceed A_W");
      end
   endgenerate

   div_state_e state;
   logic       running;
   logic       legal;
   logic       tick;
   logic       last;
   logic       sample;
   logic       take;
   logic       drop;

   assign running = (state == DIV_RUNNING);
   assign sample  = !running || last;
   assign take    = sample && legal;
   assign drop    = sample && !legal;

   psw_cfg_check #(.P(P), .N_W(N_W), .A_W(A_W)) u_check (
      .n_in  (n_val),
      .a_in  (a_val),
      .legal (legal)
   );

   psw_prescaler #(.P(P)) u_presc (
      .clk     (clk_in),
      .rst_n   (rst_n),
      .run     (running),
      .mc      (mod_ctl),
      .tick    (tick),
      .pre_out (pre_out)
   );

   psw_swallow #(.N_W(N_W), .A_W(A_W)) u_swallow (
      .clk   (clk_in),
      .rst_n (rst_n),
      .load  (take),
      .clr   (drop),
      .tick  (tick),
      .n_ld  (n_val),
      .a_ld  (a_val),
      .mc    (mod_ctl),
      .last  (last)
   );

   always_ff @(posedge clk_in) begin
      if (!rst_n) begin
         state   <= DIV_STOPPED;
         cfg_err <= 1'b0;
         div_out <= 1'b0;
      end else begin
         div_out <= last;
         if (sample) begin
            state   <= legal ? DIV_RUNNING : DIV_STOPPED;
            cfg_err <= !legal;
         end
      end
   end

   // R1: output pulse is a single clock wide
   p_pulse_single_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
      div_out |=> !div_out);

   // R4: no pulses while a rejected pair is in force
   p_err_quiet_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
      (cfg_err && $past(cfg_err)) |-> !div_out);

   // R4: stopped divider keeps modulus control high
   p_stopped_mc_high_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
      cfg_err |-> mod_ctl);

   // R3: prescaler output silent while stopped
   p_stopped_no_group_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
      cfg_err |-> !pre_out);

endmodule

// File: tb/psw_divider_bench.sv
module psw_divider_bench;
   localparam int CLK_PERIOD = 10;
   localparam int P   = 4;
   localparam int N_W = 5;
   localparam int A_W = $clog2(P);

   logic           clk_in = 1'b0;
   logic           rst_n  = 1'b0;
   logic [N_W-1:0] n_val  = '0;
   logic [A_W-1:0] a_val  = '0;
   logic           div_out;
   logic           mod_ctl;
   logic           pre_out;
   logic           cfg_err;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk_in = ~clk_in;

   psw_divider #(.P(P), .N_W(N_W)) u_psw_divider (
      .clk_in  (clk_in),
      .rst_n   (rst_n),
      .n_val   (n_val),
      .a_val   (a_val),
      .div_out (div_out),
      .mod_ctl (mod_ctl),
      .pre_out (pre_out),
      .cfg_err (cfg_err)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Starts at a negedge with div_out high; ends at the next such negedge.
   // When mid_at >= 0 the inputs are changed to (mid_n, mid_a) at that cycle.
   task automatic measure(output int cyc, output int lows, output int pres,
                          input int mid_at, input int mid_n, input int mid_a);
      cyc = 0; lows = 0; pres = 0;
      do begin
         if (!mod_ctl) lows++;
         if (pre_out)  pres++;
         if (cyc == mid_at) begin
            n_val = N_W'(mid_n);
            a_val = A_W'(mid_a);
         end
         cyc++;
         @(negedge clk_in);
      end while (!div_out && cyc < 1000);
   endtask

   task automatic check_period(input string tag, input int n, input int a,
                               input int cyc, input int lows, input int pres);
      check({tag, " period"}, cyc, n * P + a);
      check({"R2 low clocks ", tag}, lows, a * (P + 1));
      check({"R3 groups ", tag}, pres, n);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int cyc, lows, pres, pn, pa, c, pulses, lowc;
      n_val = 5'd3; a_val = 2'd1;
      repeat (3) @(negedge clk_in);
      // R7: reset values
      check("R7 div_out", int'(div_out), 0);
      check("R7 pre_out", int'(pre_out), 0);
      check("R7 cfg_err", int'(cfg_err), 0);
      check("R7 mod_ctl", int'(mod_ctl), 1);
      rst_n = 1'b1;
      c = 0;
      while (!div_out && c < 1000) begin @(negedge clk_in); c++; end
      pn = 3; pa = 1;

      // R5: mid-period change must not touch the running period
      n_val = 5'd7; a_val = 2'd2;
      measure(cyc, lows, pres, 5, 9, 3);
      check_period("R5", pn, pa, cyc, lows, pres);
      pn = 9; pa = 3;

      // full sweep over legal pairs, each period checks the pair set before
      for (int n = 1; n < (1 << N_W); n++) begin
         for (int a = 0; a < P; a++) begin
            if (a <= n) begin
               n_val = N_W'(n); a_val = A_W'(a);
               measure(cyc, lows, pres, -1, 0, 0);
               check_period((pa == 0 || pa == P - 1) ? "R8" : "R1", pn, pa, cyc, lows, pres);
               pn = n; pa = a;
            end
         end
      end

      // R8: corner pair N = A = P-1, mod_ctl low throughout
      n_val = N_W'(P - 1); a_val = A_W'(P - 1);
      measure(cyc, lows, pres, -1, 0, 0);
      check_period("R1", pn, pa, cyc, lows, pres);
      n_val = 5'd2; a_val = 2'd3;
      measure(cyc, lows, pres, -1, 0, 0);
      check_period("R8", P - 1, P - 1, cyc, lows, pres);

      // R4: illegal pair A > N is taken at the boundary just reached
      check("R4 cfg_err set", int'(cfg_err), 1);
      pulses = 0; lowc = 0;
      for (int i = 0; i < 200; i++) begin
         if (i == 100) begin n_val = 5'd0; a_val = 2'd0; end
         @(negedge clk_in);
         if (div_out) pulses++;
         if (!mod_ctl) lowc++;
      end
      check("R4 pulses while stopped", pulses, 0);
      check("R4 mod_ctl low clocks while stopped", lowc, 0);
      check("R4 cfg_err with N=0", int'(cfg_err), 1);

      // R6: recovery with a legal pair
      n_val = 5'd5; a_val = 2'd2;
      @(negedge clk_in);
      check("R6 cfg_err cleared", int'(cfg_err), 0);
      c = 0;
      while (!div_out && c < 1000) begin @(negedge clk_in); c++; end
      check("R6 first pulse delay", c, 5 * P + 2);
      n_val = 5'd11; a_val = 2'd0;
      measure(cyc, lows, pres, -1, 0, 0);
      check_period("R6", 5, 2, cyc, lows, pres);
      measure(cyc, lows, pres, -1, 0, 0);
      check_period("R8", 11, 0, cyc, lows, pres);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule